// File: doc/BRIEF.md
# Indexed Board Status Register Port

This block places a bank of byte-wide board registers behind two I/O ports, so only a small window of I/O space is used. Software writes a register number to the index port. It then reads or writes the selected register through the data port. The index keeps its value until software writes the index port again, so repeated data accesses all reach the same register.

One register is loaded at reset from board strap inputs, so firmware can learn how the board is clocked. That register holds four fields:

- a bus clock code,
- a two-bit CPU multiplier code, whose two bits sit apart in the byte,
- a flag that says booting is allowed,
- zeros in every other bit.

After reset, software may overwrite this register like any other.

The decoded window is aligned and spans several port addresses. Its first two offsets are the index port and the data port. Reads of the other offsets in the window return all ones. Reads outside the window return zero, so the read data can be OR-ed onto a shared bus. Reads are combinational while the read strobe is high. Writes take effect at the rising clock edge.

Top module: `brd_readout_port`

## Requirements
- R1: A write to window offset 0 (address 0xE0 by default) loads the index from the low write-data bits. A read of offset 0 returns the current index, zero-extended.
- R2: A read of window offset 1 (0xE1) returns the register selected by the index. A write of offset 1 updates only that register, at the next rising edge.
- R3: The index does not change after data-port reads or writes. It does not auto-increment.
- R4: A read of window offsets 2 and 3 (0xE2, 0xE3) returns 0xFF. Writes to these offsets change neither the index nor any register.
- R5: A read of an address outside the window returns 0x00. Writes outside the window are ignored.
- R6: While reset is held low at a clock edge, the index and every register except register 1 are cleared to 0x00.
- R7: At reset, register 1 is loaded as follows:
  - bit 6 is set to 1 (boot allowed);
  - bits 5:4 take the bus code (00 = 50 MHz, 01 = 66 MHz, 10 = 60 MHz);
  - bit 7 takes the high bit of the multiplier code and bit 1 its low bit (00 = 2.5, 01 = 2.0, 10 = 3.0, 11 = 1.5);
  - bits 3, 2 and 0 are 0.
- R8: After reset, register 1 can be overwritten through the data port, and reads return the written value.
- R9: When the read and write strobes are both high on the data port in one cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | ADDR_W (16) | I/O port address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | DATA_W (8) | Write data |
| io_rdata | output | DATA_W (8) | Read data, combinational, zero when not selected |
| strap_bus_code | input | 2 | Bus clock code sampled during reset |
| strap_mult_code | input | 2 | Multiplier code sampled during reset |

## Verification
The bound checker checks these rules on every cycle:
- the fixed read values of the spare offsets and of addresses outside the window;
- that the index holds whenever the index port is not written;
- that an index write or a data write is read back on the following cycle.

Only the bench's scenarios can show the following:
- the reset contents of register 1 for different strap settings;
- that the other registers are cleared by a later reset after software wrote them;
- that writes to the spare offsets and to addresses outside the window leave everything unchanged;
- the value returned by a read and a write in the same cycle.

// File: rtl/brd_readout_pkg.sv
package brd_readout_pkg;
   // Bit positions inside the strap-loaded register
   localparam int MULT_HI_BIT = 7;
   localparam int BOOT_BIT    = 6;
   localparam int BUS_HI_BIT  = 5;
   localparam int BUS_LO_BIT  = 4;
   localparam int MULT_LO_BIT = 1;

   typedef enum logic [1:0] {
      PORT_NONE  = 2'd0,
      PORT_INDEX = 2'd1,
      PORT_DATA  = 2'd2,
      PORT_SPARE = 2'd3
   } port_sel_e;

   function automatic logic [7:0] pack_straps(input logic [1:0] bus_code,
                                              input logic [1:0] mult_code);
      logic [7:0] v;
      v              = '0;
      v[BOOT_BIT]    = 1'b1;
      v[BUS_HI_BIT]  = bus_code[1];
      v[BUS_LO_BIT]  = bus_code[0];
      v[MULT_HI_BIT] = mult_code[1];
      v[MULT_LO_BIT] = mult_code[0];
      return v;
   endfunction
endpackage

// File: rtl/brd_port_decode.sv
module brd_port_decode
   import brd_readout_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int BASE     = 'hE0,
   parameter int WIN_LOG2 = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output port_sel_e         sel
);
   localparam int HI_W = ADDR_W - WIN_LOG2;
   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);

   generate
      if (WIN_LOG2 < 1 || WIN_LOG2 >= ADDR_W) begin : g_bad_win
         $error("brd_port_decode: WIN_LOG2 out of range");
      end
      if ((BASE % (1 << WIN_LOG2)) != 0) begin : g_bad_base
         $error("brd_port_decode: BASE must be window aligned");
      end
   endgenerate

   logic            in_win;
   logic [WIN_LOG2-1:0] offs;

   assign in_win = (addr[ADDR_W-1:WIN_LOG2] == BASE_A[ADDR_W-1:WIN_LOG2]);
   assign offs   = addr[WIN_LOG2-1:0];

   always_comb begin
      if (!in_win)                          sel = PORT_NONE;
      else if (offs == WIN_LOG2'(0))        sel = PORT_INDEX;
      else if (offs == WIN_LOG2'(1))        sel = PORT_DATA;
      else                                  sel = PORT_SPARE;
   end

   logic unused_hi;
   assign unused_hi = ^HI_W;
endmodule

// File: rtl/brd_index_reg.sv
module brd_index_reg #(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IDX_W-1:0] din,
   output logic [IDX_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= din;
   end
endmodule

// File: rtl/brd_reg_file.sv
module brd_reg_file #(
   parameter int IDX_W      = 8,
   parameter int DATA_W     = 8,
   parameter int PRESET_IDX = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  raddr,
   input  logic [DATA_W-1:0] preset_val,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << IDX_W;

   generate
      if (PRESET_IDX < 0 || PRESET_IDX >= DEPTH) begin : g_bad_preset
         $error("brd_reg_file: PRESET_IDX outside register range");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic hit;
      assign hit = we && (waddr == IDX_W'(i));
      if (i == PRESET_IDX) begin : g_strap
         always_ff @(posedge clk) begin
            if (!rst_n)   mem[i] <= preset_val;
            else if (hit) mem[i] <= wdata;
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (!rst_n)   mem[i] <= '0;
            else if (hit) mem[i] <= wdata;
         end
      end
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/brd_readout_port.sv
module brd_readout_port
   import brd_readout_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 8,
   parameter int IDX_W    = 8,
   parameter int BASE     = 'hE0,
   parameter int WIN_LOG2 = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_rd,
   input  logic              io_wr,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rdata,
   input  logic [1:0]        strap_bus_code,
   input  logic [1:0]        strap_mult_code
);
   localparam int STRAP_IDX = 1;
   localparam logic [DATA_W-1:0] SPARE_VAL = '1;

   generate
      if (DATA_W < 8) begin : g_bad_data
         $error("brd_readout_port: DATA_W must hold the strap byte");
      end
      if (IDX_W > DATA_W || IDX_W > 10) begin : g_bad_idx
         $error("brd_readout_port: IDX_W too wide");
      end
   endgenerate

   port_sel_e         sel;
   logic [IDX_W-1:0]  cur_idx;
   logic [DATA_W-1:0] rf_rdata;
   logic [DATA_W-1:0] strap_val;

   assign strap_val = DATA_W'(pack_straps(strap_bus_code, strap_mult_code));

   brd_port_decode #(
      .ADDR_W(ADDR_W), .BASE(BASE), .WIN_LOG2(WIN_LOG2)
   ) i_dec (
      .addr(io_addr), .sel(sel)
   );

   brd_index_reg #(.IDX_W(IDX_W)) i_idx (
      .clk(clk), .rst_n(rst_n),
      .load(io_wr && (sel == PORT_INDEX)),
      .din(io_wdata[IDX_W-1:0]),
      .q(cur_idx)
   );

   brd_reg_file #(
      .IDX_W(IDX_W), .DATA_W(DATA_W), .PRESET_IDX(STRAP_IDX)
   ) i_rf (
      .clk(clk), .rst_n(rst_n),
      .we(io_wr && (sel == PORT_DATA)),
      .waddr(cur_idx), .wdata(io_wdata),
      .raddr(cur_idx), .preset_val(strap_val),
      .rdata(rf_rdata)
   );

   always_comb begin
      io_rdata = '0;
      if (io_rd) begin
         unique case (sel)
            PORT_INDEX: io_rdata = DATA_W'(cur_idx);
            PORT_DATA:  io_rdata = rf_rdata;
            PORT_SPARE: io_rdata = SPARE_VAL;
            default:    io_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/brd_readout_chk.sv
module brd_readout_chk #(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 8,
   parameter int IDX_W    = 8,
   parameter int BASE     = 'hE0,
   parameter int WIN_LOG2 = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic              io_rd,
   input logic              io_wr,
   input logic [DATA_W-1:0] io_wdata,
   input logic [DATA_W-1:0] io_rdata,
   input logic [IDX_W-1:0]  cur_idx
);
   localparam logic [ADDR_W-1:0] A_IDX  = ADDR_W'(BASE);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(BASE + 1);

   logic win;
   assign win = ((io_addr >> WIN_LOG2) == (A_IDX >> WIN_LOG2));

   // R5
   outside_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && !win) |-> (io_rdata == '0));

   // R4
   spare_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && win && io_addr != A_IDX && io_addr != A_DATA) |-> (io_rdata == '1));

   // R3
   idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_wr && io_addr == A_IDX) |=> $stable(cur_idx));

   // R1
   idx_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(io_wr && io_addr == A_IDX) && io_rd && io_addr == A_IDX)
      |-> (io_rdata == DATA_W'($past(io_wdata[IDX_W-1:0]))));

   // R2
   data_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(io_wr && io_addr == A_DATA) && io_rd && io_addr == A_DATA && $stable(cur_idx))
      |-> (io_rdata == $past(io_wdata)));
endmodule

bind brd_readout_port brd_readout_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .BASE(BASE), .WIN_LOG2(WIN_LOG2)
) i_chk (
   .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
   .io_wdata(io_wdata), .io_rdata(io_rdata), .cur_idx(cur_idx)
);

// File: tb/test_brd_readout_port.sv
module test_brd_readout_port;
   logic        clk = 0;
   logic        rst_n = 0;
   logic [15:0] io_addr = '0;
   logic        io_rd = 0, io_wr = 0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic [1:0]  strap_bus_code = 2'b01, strap_mult_code = 2'b10;
   int          errs = 0, checks = 0;

   always #10 clk = ~clk;

   brd_readout_port i_brd_readout_port (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
      .io_wdata(io_wdata), .io_rdata(io_rdata),
      .strap_bus_code(strap_bus_code), .strap_mult_code(strap_mult_code)
   );

   // fields: op(2) 1=write 2=read | addr(16) | wdata(8) | expect(8) | req(8)
   localparam int NV = 27;
   localparam logic [41:0] VEC [NV] = '{
      {2'd2, 16'h00E0, 8'h00, 8'h00, 8'd6},  // R6 index cleared
      {2'd2, 16'h00E1, 8'h00, 8'h00, 8'd6},  // R6 reg0 cleared
      {2'd1, 16'h00E0, 8'h01, 8'h00, 8'd1},
      {2'd2, 16'h00E0, 8'h00, 8'h01, 8'd1},  // R1 index readback
      {2'd2, 16'h00E1, 8'h00, 8'hD0, 8'd7},  // R7 bus 66, mult 3.0
      {2'd1, 16'h00E1, 8'h5A, 8'h00, 8'd8},
      {2'd2, 16'h00E1, 8'h00, 8'h5A, 8'd8},  // R8 overwrite reg1
      {2'd2, 16'h00E0, 8'h00, 8'h01, 8'd3},  // R3 no auto-increment
      {2'd1, 16'h00E0, 8'hFF, 8'h00, 8'd1},
      {2'd2, 16'h00E1, 8'h00, 8'h00, 8'd6},  // R6 top reg cleared
      {2'd1, 16'h00E1, 8'hA5, 8'h00, 8'd2},
      {2'd2, 16'h00E1, 8'h00, 8'hA5, 8'd2},  // R2 write/read
      {2'd1, 16'h00E0, 8'h80, 8'h00, 8'd1},
      {2'd1, 16'h00E1, 8'h3C, 8'h00, 8'd2},
      {2'd2, 16'h00E1, 8'h00, 8'h3C, 8'd2},  // R2 second reg
      {2'd1, 16'h00E0, 8'hFF, 8'h00, 8'd1},
      {2'd2, 16'h00E1, 8'h00, 8'hA5, 8'd2},  // R2 other reg untouched
      {2'd2, 16'h00E2, 8'h00, 8'hFF, 8'd4},  // R4 spare reads
      {2'd2, 16'h00E3, 8'h00, 8'hFF, 8'd4},
      {2'd1, 16'h00E2, 8'h77, 8'h00, 8'd4},
      {2'd1, 16'h00E3, 8'h11, 8'h00, 8'd4},
      {2'd2, 16'h00E0, 8'h00, 8'hFF, 8'd4},  // R4 index unchanged
      {2'd2, 16'h00E1, 8'h00, 8'hA5, 8'd4},  // R4 reg unchanged
      {2'd2, 16'h0010, 8'h00, 8'h00, 8'd5},  // R5 outside reads zero
      {2'd1, 16'h01E0, 8'h33, 8'h00, 8'd5},
      {2'd1, 16'h01E1, 8'h44, 8'h00, 8'd5},
      {2'd2, 16'h00E1, 8'h00, 8'hA5, 8'd5}   // R5 writes outside ignored
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1;
      @(negedge clk);
      io_wr = 0;
   endtask

   task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string req);
      @(negedge clk);
      io_addr = a; io_rd = 1;
      #5 chk(req, io_rdata, exp);
      @(posedge clk);
      #1 io_rd = 0;
   endtask

   task automatic do_reset(input logic [1:0] bc, input logic [1:0] mc);
      @(negedge clk);
      rst_n = 0; strap_bus_code = bc; strap_mult_code = mc;
      repeat (3) @(negedge clk);
      rst_n = 1;
   endtask

   initial begin
      do_reset(2'b01, 2'b10);
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][41:40] == 2'd1)
            wr(VEC[i][39:24], VEC[i][23:16]);
         else
            rd(VEC[i][39:24], VEC[i][15:8], $sformatf("R%0d vec%0d", VEC[i][7:0], i));
      end
      // R9 read and write together on the data port
      wr(16'h00E0, 8'h02);
      wr(16'h00E1, 8'h11);
      @(negedge clk);
      io_addr = 16'h00E1; io_wdata = 8'h22; io_rd = 1; io_wr = 1;
      #5 chk("R9 old value", io_rdata, 8'h11);
      @(negedge clk);
      io_wr = 0; io_rd = 0;
      rd(16'h00E1, 8'h22, "R9 new value");
      // R6 and R7 with other strap settings
      do_reset(2'b10, 2'b11);
      wr(16'h00E0, 8'h01);
      rd(16'h00E1, 8'hE2, "R7 bus 60 mult 1.5");
      wr(16'h00E0, 8'hFF);
      rd(16'h00E1, 8'h00, "R6 cleared after rewrite");
      wr(16'h00E0, 8'h02);
      rd(16'h00E1, 8'h00, "R6 reg2 cleared");
      do_reset(2'b00, 2'b01);
      rd(16'h00E0, 8'h00, "R6 index cleared");
      wr(16'h00E0, 8'h01);
      rd(16'h00E1, 8'h42, "R7 bus 50 mult 2.0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      #1000000;
      errs++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule